// File: doc/BRIEF.md
# Flag-Matched Next-PC Unit with Return-Address Stack

This block holds the program counter of a small processor and chooses the next one each cycle. It takes the decoded opcode, a target address, a flag pattern and a flag mask from the current instruction, along with the live condition flags of the ALU. It produces the next PC combinationally and loads it into the PC register on the next clock edge. One instruction is retired on every clock.

A branch is taken when the live flags match the instruction's pattern in every bit the mask selects. A mask of all zeros therefore makes the branch unconditional. A linked branch saves the PC on a small hardware stack of return addresses. A return instruction pops that stack and jumps to the popped address, so call and return need no data memory. When the stack is misused, the unit raises a sticky overflow or underflow flag instead of corrupting its contents.

Top module: `flagbr_nextpc`

## Requirements
- R1: A synchronous reset, sampled on a rising edge, sets `pc` to zero, empties the return stack and clears `ras_overflow` and `ras_underflow`.
- R2: The opcodes are encoded on `op` as follows: 4'b1100 is branch, 4'b1101 is branch-and-link, 4'b0110 is return and 4'b0000 is no-operation. Every other code, and every branch or branch-and-link that is not taken, makes the next PC equal to `pc + 1`, modulo 2^PC_W.
- R3: A branch is taken exactly when `(alu_flags & flag_en) == (flag_pat & flag_en)`. When it is taken, the next PC is `tgt_addr`.
- R4: When `flag_en` is all zeros, a branch or branch-and-link is taken whatever the values of `flag_pat` and `alu_flags`.
- R5: A taken branch-and-link pushes the current `pc` onto the return stack. A branch-and-link that is not taken leaves the stack unchanged.
- R6: A return on a non-empty stack pops the most recently pushed address and makes it the next PC, in last-in, first-out order.
- R7: A taken branch-and-link on a full stack (RAS_DEPTH entries, 8 by default) sets `ras_overflow`. The push is discarded, the stored entries are kept, and the branch is still taken.
- R8: A return on an empty stack sets `ras_underflow` and makes the next PC equal to `pc + 1`.
- R9: `ras_overflow` and `ras_underflow` stay set until a reset.
- R10: `next_pc` shows the value that `pc` takes on the next rising edge while reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Decoded opcode of the current instruction |
| tgt_addr | input | PC_W | Branch target address |
| flag_pat | input | FLAG_W | Flag values the branch expects |
| flag_en | input | FLAG_W | Selects which flag bits are compared |
| alu_flags | input | FLAG_W | Live ALU condition flags |
| pc | output | PC_W | Current program counter |
| next_pc | output | PC_W | Program counter for the next cycle |
| ras_overflow | output | 1 | Sticky flag: a push was attempted on a full stack |
| ras_underflow | output | 1 | Sticky flag: a pop was attempted on an empty stack |

## Verification
The bench fills the stack to its limit and then makes a ninth call. A design that wrapped its pointer would overwrite the oldest entry, and the eight returns that follow would land at the wrong addresses. A design that cancelled the branch on overflow would show the wrong `pc`. The bench also pops an empty stack. A design that did not guard the pointer would jump to a stale entry instead of advancing. Masked compares are driven with mismatches confined to disabled bits and with mismatches on enabled bits. A design that compared unmasked bits would take the wrong path. Untaken linked branches are followed by returns, which exposes a design that pushed regardless of the condition.

// File: rtl/flagbr_pkg.sv
package flagbr_pkg;
   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_NOP  = 4'b0000,
      OPC_RET  = 4'b0110,
      OPC_BR   = 4'b1100,
      OPC_CALL = 4'b1101
   } opc_e;

   typedef enum logic [1:0] {
      SEL_SEQ,
      SEL_TGT,
      SEL_POP
   } pc_src_e;
endpackage

// File: rtl/flagbr_cond.sv
// Masked flag comparison: every enabled bit must agree with the pattern.
module flagbr_cond #(
   parameter int FLAG_W = 4
) (
   input  logic [FLAG_W-1:0] pat,
   input  logic [FLAG_W-1:0] en,
   input  logic [FLAG_W-1:0] flags,
   output logic              hit
);
   if (FLAG_W < 1) begin : g_bad_w
      $error("flagbr_cond: FLAG_W must be at least 1");
   end

   logic [FLAG_W-1:0] miss;

   for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
      assign miss[b] = en[b] & (pat[b] ^ flags[b]);
   end

   assign hit = ~|miss;
endmodule

// File: rtl/flagbr_ras.sv
// Return-address stack with count pointer and sticky misuse flags.
module flagbr_ras #(
   parameter int AW    = 8,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic          pop,
   input  logic [AW-1:0] push_data,
   output logic [AW-1:0] top,
   output logic          empty,
   output logic          full,
   output logic          ovf,
   output logic          unf
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("flagbr_ras: DEPTH must be at least 2");
   end
   if (AW < 1) begin : g_bad_aw
      $error("flagbr_ras: AW must be at least 1");
   end

   logic [AW-1:0]    mem [DEPTH];
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_dec;
   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] rd_idx;
   logic             do_push;
   logic             do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == FULL_CNT);
   assign cnt_dec = cnt - 1'b1;
   assign wr_idx  = IDX_W'(cnt);
   assign rd_idx  = IDX_W'(cnt_dec);
   assign top     = mem[rd_idx];
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         ovf <= 1'b0;
         unf <= 1'b0;
      end else begin
         if (do_push) cnt <= cnt + 1'b1;
         else if (do_pop) cnt <= cnt_dec;
         if (push & full) ovf <= 1'b1;
         if (pop & empty) unf <= 1'b1;
      end
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst && do_push && (wr_idx == IDX_W'(e)))
            mem[e] <= push_data;
      end
   end
endmodule

// File: rtl/flagbr_pcsel.sv
// Opcode decode and next-PC source selection.
module flagbr_pcsel #(
   parameter int PC_W = 8
) (
   input  logic [flagbr_pkg::OPC_W-1:0] op,
   input  logic                         hit,
   input  logic                         stk_empty,
   input  logic [PC_W-1:0]              pc,
   input  logic [PC_W-1:0]              tgt,
   input  logic [PC_W-1:0]              stk_top,
   output logic [PC_W-1:0]              nxt,
   output logic                         push,
   output logic                         pop
);
   import flagbr_pkg::*;

   pc_src_e src;

   always_comb begin
      src  = SEL_SEQ;
      push = 1'b0;
      pop  = 1'b0;
      case (op)
         OPC_BR: begin
            if (hit) src = SEL_TGT;
         end
         OPC_CALL: begin
            if (hit) begin
               src  = SEL_TGT;
               push = 1'b1;
            end
         end
         OPC_RET: begin
            pop = 1'b1;
            if (!stk_empty) src = SEL_POP;
         end
         default: src = SEL_SEQ;
      endcase
   end

   always_comb begin
      case (src)
         SEL_TGT: nxt = tgt;
         SEL_POP: nxt = stk_top;
         default: nxt = pc + 1'b1;
      endcase
   end
endmodule

// File: rtl/flagbr_nextpc.sv
module flagbr_nextpc #(
   parameter int PC_W      = 8,
   parameter int FLAG_W    = 4,
   parameter int RAS_DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [flagbr_pkg::OPC_W-1:0] op,
   input  logic [PC_W-1:0]              tgt_addr,
   input  logic [FLAG_W-1:0]            flag_pat,
   input  logic [FLAG_W-1:0]            flag_en,
   input  logic [FLAG_W-1:0]            alu_flags,
   output logic [PC_W-1:0]              pc,
   output logic [PC_W-1:0]              next_pc,
   output logic                         ras_overflow,
   output logic                         ras_underflow
);
   if (PC_W < 2) begin : g_bad_pcw
      $error("flagbr_nextpc: PC_W must be at least 2");
   end

   logic            cond_hit;
   logic            stk_push;
   logic            stk_pop;
   logic            stk_empty;
   logic            stk_full;
   logic [PC_W-1:0] stk_top;

   flagbr_cond #(.FLAG_W(FLAG_W)) cond_i (
      .pat   (flag_pat),
      .en    (flag_en),
      .flags (alu_flags),
      .hit   (cond_hit)
   );

   flagbr_pcsel #(.PC_W(PC_W)) sel_i (
      .op        (op),
      .hit       (cond_hit),
      .stk_empty (stk_empty),
      .pc        (pc),
      .tgt       (tgt_addr),
      .stk_top   (stk_top),
      .nxt       (next_pc),
      .push      (stk_push),
      .pop       (stk_pop)
   );

   flagbr_ras #(.AW(PC_W), .DEPTH(RAS_DEPTH)) ras_i (
      .clk       (clk),
      .rst       (rst),
      .push      (stk_push),
      .pop       (stk_pop),
      .push_data (pc),
      .top       (stk_top),
      .empty     (stk_empty),
      .full      (stk_full),
      .ovf       (ras_overflow),
      .unf       (ras_underflow)
   );

   always_ff @(posedge clk) begin
      if (rst) pc <= '0;
      else     pc <= next_pc;
   end
endmodule

// File: rtl/flagbr_nextpc_chk.sv
module flagbr_nextpc_chk #(
   parameter int PC_W   = 8,
   parameter int FLAG_W = 4
) (
   input logic                         clk,
   input logic                         rst,
   input logic [flagbr_pkg::OPC_W-1:0] op,
   input logic [PC_W-1:0]              tgt_addr,
   input logic [FLAG_W-1:0]            flag_en,
   input logic [PC_W-1:0]              pc,
   input logic [PC_W-1:0]              next_pc,
   input logic                         ovf,
   input logic                         unf,
   input logic                         stk_empty,
   input logic                         stk_full
);
   import flagbr_pkg::*;

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (pc == '0) && !ovf && !unf && stk_empty);

   assert_nop_advance_R2: assert property (@(posedge clk) disable iff (rst)
      (op == OPC_NOP) |-> (next_pc == PC_W'(pc + 1'b1)));

   assert_open_branch_R4: assert property (@(posedge clk) disable iff (rst)
      ((op == OPC_BR) && (flag_en == '0)) |-> (next_pc == tgt_addr));

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
      ((op == OPC_CALL) && (flag_en == '0) && stk_full) |=> ovf && stk_full);

   assert_underflow_R8: assert property (@(posedge clk) disable iff (rst)
      ((op == OPC_RET) && stk_empty) |=> unf && (pc == PC_W'($past(pc) + 1'b1)));

   assert_sticky_ovf_R9: assert property (@(posedge clk) disable iff (rst)
      ovf |=> ovf);

   assert_sticky_unf_R9: assert property (@(posedge clk) disable iff (rst)
      unf |=> unf);

   assert_pc_load_R10: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (pc == $past(next_pc)));
endmodule

bind flagbr_nextpc flagbr_nextpc_chk #(.PC_W(PC_W), .FLAG_W(FLAG_W)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .op        (op),
   .tgt_addr  (tgt_addr),
   .flag_en   (flag_en),
   .pc        (pc),
   .next_pc   (next_pc),
   .ovf       (ras_overflow),
   .unf       (ras_underflow),
   .stk_empty (stk_empty),
   .stk_full  (stk_full)
);

// File: tb/flagbr_nextpc_tb_top.sv
module flagbr_nextpc_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int PC_W       = 8;
   localparam int FLAG_W     = 4;
   localparam int DEPTH      = 8;
   localparam logic [3:0] K_NOP  = 4'b0000;
   localparam logic [3:0] K_RET  = 4'b0110;
   localparam logic [3:0] K_BR   = 4'b1100;
   localparam logic [3:0] K_CALL = 4'b1101;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [3:0]        op = K_NOP;
   logic [PC_W-1:0]   tgt_addr = '0;
   logic [FLAG_W-1:0] flag_pat = '0;
   logic [FLAG_W-1:0] flag_en = '0;
   logic [FLAG_W-1:0] alu_flags = '0;
   logic [PC_W-1:0]   pc;
   logic [PC_W-1:0]   next_pc;
   logic              ras_overflow;
   logic              ras_underflow;

   int checks = 0;
   int fails  = 0;

   logic [PC_W-1:0] m_pc;
   logic [PC_W-1:0] m_stk [DEPTH];
   int              m_cnt;
   logic            m_ovf;
   logic            m_unf;

   always #(CLK_PERIOD/2) clk = ~clk;

   flagbr_nextpc #(.PC_W(PC_W), .FLAG_W(FLAG_W), .RAS_DEPTH(DEPTH)) dut_i (
      .clk           (clk),
      .rst           (rst),
      .op            (op),
      .tgt_addr      (tgt_addr),
      .flag_pat      (flag_pat),
      .flag_en       (flag_en),
      .alu_flags     (alu_flags),
      .pc            (pc),
      .next_pc       (next_pc),
      .ras_overflow  (ras_overflow),
      .ras_underflow (ras_underflow)
   );

   function automatic logic f_hit(logic [FLAG_W-1:0] p, logic [FLAG_W-1:0] e,
                                  logic [FLAG_W-1:0] f);
      return ((f & e) == (p & e));
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      op  = K_NOP;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_pc = '0; m_cnt = 0; m_ovf = 1'b0; m_unf = 1'b0;
      check("R1 pc", pc, 0);
      check("R1 ovf", ras_overflow, 0);
      check("R1 unf", ras_underflow, 0);
   endtask

   // One instruction: drive at negedge, check next_pc, clock, check state.
   task automatic step(logic [3:0] o, logic [PC_W-1:0] t, logic [FLAG_W-1:0] p,
                       logic [FLAG_W-1:0] e, logic [FLAG_W-1:0] f);
      logic [PC_W-1:0] nx;
      logic            h;
      string           tag;
      op = o; tgt_addr = t; flag_pat = p; flag_en = e; alu_flags = f;
      h = f_hit(p, e, f);
      nx = m_pc + 1'b1;
      tag = "R2";
      case (o)
         K_BR: begin
            tag = (e == '0) ? "R4" : "R3";
            if (h) nx = t;
         end
         K_CALL: begin
            tag = "R5";
            if (h) begin
               nx = t;
               if (m_cnt == DEPTH) begin m_ovf = 1'b1; tag = "R7"; end
               else begin m_stk[m_cnt] = m_pc; m_cnt++; end
            end
         end
         K_RET: begin
            if (m_cnt == 0) begin m_unf = 1'b1; tag = "R8"; end
            else begin m_cnt--; nx = m_stk[m_cnt]; tag = "R6"; end
         end
         default: tag = "R2";
      endcase
      #1;
      check({tag, " R10 next_pc"}, next_pc, nx);
      @(posedge clk);
      @(negedge clk);
      m_pc = nx;
      check({tag, " pc"}, pc, m_pc);
      check("R7 R9 ovf", ras_overflow, m_ovf);
      check("R8 R9 unf", ras_underflow, m_unf);
   endtask

   initial begin
      void'($urandom(32'h5eed_0c11));
      do_reset();
      // R8: pop on empty advances and flags
      step(K_RET, 8'h40, 4'h0, 4'h0, 4'h0);
      step(K_NOP, 8'h00, 4'h0, 4'h0, 4'h0);
      check("R9 unf held", ras_underflow, 1);
      do_reset();
      // R4: zero mask always taken, even with disagreeing flags
      step(K_BR, 8'h30, 4'hF, 4'h0, 4'h0);
      // R3: mismatch only on disabled bits -> taken
      step(K_BR, 8'h55, 4'b1010, 4'b0011, 4'b0110);
      // R3: mismatch on enabled bit -> not taken
      step(K_BR, 8'h77, 4'b1010, 4'b1000, 4'b0010);
      // R2: undefined opcode advances
      step(4'b0011, 8'h99, 4'h0, 4'h0, 4'h0);
      // R5: untaken call pushes nothing; return then underflows
      step(K_CALL, 8'h20, 4'b0001, 4'b0001, 4'b0000);
      step(K_RET, 8'h00, 4'h0, 4'h0, 4'h0);
      do_reset();
      // R7: nine taken calls, last one overflows but still branches
      for (int i = 0; i < DEPTH + 1; i++)
         step(K_CALL, PC_W'(8'h10 * (i + 1)), 4'h0, 4'h0, 4'h0);
      check("R7 ovf set", ras_overflow, 1);
      step(K_NOP, 8'h00, 4'h0, 4'h0, 4'h0);
      // R6: LIFO returns, original entries kept
      for (int i = 0; i < DEPTH; i++)
         step(K_RET, 8'h00, 4'h0, 4'h0, 4'h0);
      step(K_RET, 8'h00, 4'h0, 4'h0, 4'h0);
      check("R9 ovf held", ras_overflow, 1);
      do_reset();
      // PC wraps at the top of the address range (R2)
      step(K_BR, 8'hFF, 4'h0, 4'h0, 4'h0);
      step(K_NOP, 8'h00, 4'h0, 4'h0, 4'h0);
      do_reset();
      // Constrained random mix
      for (int n = 0; n < 600; n++) begin
         int          r;
         logic [3:0]  o;
         logic [FLAG_W-1:0] e;
         r = int'($urandom % 8);
         case (r)
            0, 1:    o = K_BR;
            2, 3:    o = K_CALL;
            4, 5:    o = K_RET;
            6:       o = K_NOP;
            default: o = 4'($urandom);
         endcase
         e = (($urandom % 4) == 0) ? '0 : FLAG_W'($urandom);
         step(o, PC_W'($urandom), FLAG_W'($urandom), e, FLAG_W'($urandom));
         if (n == 300) do_reset();
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule